// File: doc/BRIEF.md
# Liveness-Aware Register File Cache

This block is a small, fully associative cache that sits between the execution lanes of a multithreaded SIMT core and its large banked register file. The cache is split into separate per-warp sets, and each set is searched by register number. A value is captured only when an instruction writes a destination register. Later source reads that find the register are served from the cache. A source read that misses goes to the main register file, and the cache is left as it was.

Within a warp, replacement follows the order in which entries were allocated. A write also carries a liveness hint, and a read carries a last-read hint. When a live entry is pushed out, it is sent back to the main register file on a one-cycle writeback strobe. A value that is dead (written as dead, or consumed by its last read) disappears without any writeback.

Lookup is combinational: hit and data are valid in the cycle the read is presented. All state changes take effect at the next clock edge. The writeback strobe appears in the cycle after the write that caused the eviction.

Top module: `liveRegCache`

## Requirements
- R1: After reset every entry is empty, rdHit is 0 for any lookup, and wbValid is 0.
- R2: A write to a register not present in its warp allocates an entry. From the next cycle, a read of that warp and register returns rdHit=1 and the written data in the same cycle.
- R3: A read that misses gives rdHit=0 and rdData=0. It allocates nothing and does not move the warp's replacement order.
- R4: Warps are isolated: a register written in one warp never hits for a lookup from another warp.
- R5: Each warp holds ENTRIES entries (default 6). An allocation into a full ring replaces the oldest allocation. If the replaced entry is valid and live, wbValid is high for exactly one cycle, the cycle after the write, with wbWarp, wbReg and wbData of the replaced value.
- R6: A value written with wrLive=0 is replaced later without any writeback.
- R7: A read hit with rdLast=1 returns the data and invalidates the entry at the clock edge. The entry then misses, and its slot is later reused without writeback.
- R8: A write to a register already present in the warp updates data and live flag in place. It allocates nothing, and the replacement order is unchanged.
- R9: When a write and a last-read of the same register in the same warp fall in one cycle, the read returns the old data and the entry afterwards holds the new data and stays valid.
- R10: When an allocation replaces an entry that a last-read consumes in the same cycle, no writeback is issued.
- R11: A read hit with rdLast=0 leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Destination write strobe |
| wrWarp | input | WARP_W | Warp of the write |
| wrReg | input | REG_W | Register number written |
| wrData | input | DATA_W | Value written |
| wrLive | input | 1 | 1 if the value will be read again |
| rdValid | input | 1 | Source lookup strobe |
| rdWarp | input | WARP_W | Warp of the lookup |
| rdReg | input | REG_W | Register number looked up |
| rdLast | input | 1 | 1 if this read is the value's final use |
| rdHit | output | 1 | Lookup found the register (combinational) |
| rdData | output | DATA_W | Cached value on hit, zero on miss |
| wbValid | output | 1 | Writeback strobe to the main register file |
| wbWarp | output | WARP_W | Warp of the written-back value |
| wbReg | output | REG_W | Register number written back |
| wbData | output | DATA_W | Value written back |

## Verification
The write port and the lookup port act in the same cycle. The bench provokes the two interesting collisions by driving both ports together. In the first, the write updates, in place, the very register that the last-read is consuming (R9). In the second, the write allocates into the slot at the head of the replacement ring while the lookup retires that slot with a last-read (R10). The first case is judged by the combinational read data in that cycle and by a follow-up lookup that must return the new value. The second is judged by the writeback scoreboard, which must see no strobe in the following cycle.

// File: rtl/rfcPkg.sv
package rfcPkg;
  localparam int unsigned SLOT_IDX_W = 4;

  typedef struct packed {
    logic                  allocEn;
    logic                  updEn;
    logic [SLOT_IDX_W-1:0] wrSlot;
    logic                  invEn;
    logic [SLOT_IDX_W-1:0] invSlot;
    logic                  evictEn;
  } rfcStrobeT;
endpackage

// File: rtl/rfcData.sv
module rfcData
  import rfcPkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned ENTRIES   = 6,
  parameter int unsigned REG_W     = 6,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned WARP_W   = $clog2(NUM_WARPS),
  localparam int unsigned SLOT_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WARP_W-1:0]  wrWarp,
  input  logic [REG_W-1:0]   wrReg,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrLive,
  input  logic               rdValid,
  input  logic [WARP_W-1:0]  rdWarp,
  input  logic [REG_W-1:0]   rdReg,
  input  rfcStrobeT          strobe,
  output logic [ENTRIES-1:0] wrMatch,
  output logic [ENTRIES-1:0] wrSlotValid,
  output logic [ENTRIES-1:0] wrSlotLive,
  output logic [ENTRIES-1:0] rdMatch,
  output logic [DATA_W-1:0]  rdData,
  output logic               wbValid,
  output logic [WARP_W-1:0]  wbWarp,
  output logic [REG_W-1:0]   wbReg,
  output logic [DATA_W-1:0]  wbData
);
  logic [NUM_WARPS-1:0][ENTRIES-1:0]              validQ;
  logic [NUM_WARPS-1:0][ENTRIES-1:0]              liveQ;
  logic [NUM_WARPS-1:0][ENTRIES-1:0][REG_W-1:0]   regQ;
  logic [NUM_WARPS-1:0][ENTRIES-1:0][DATA_W-1:0]  dataQ;

  logic [SLOT_W-1:0] wrSlotIdx;
  assign wrSlotIdx = strobe.wrSlot[SLOT_W-1:0];

  // Per-entry tag comparators for both ports
  for (genvar e = 0; e < ENTRIES; e++) begin : gCompare
    assign wrMatch[e] = validQ[wrWarp][e] && (regQ[wrWarp][e] == wrReg);
    assign rdMatch[e] = rdValid && validQ[rdWarp][e] && (regQ[rdWarp][e] == rdReg);
  end

  assign wrSlotValid = validQ[wrWarp];
  assign wrSlotLive  = liveQ[wrWarp];

  // One-hot read mux; zero when nothing matches
  always_comb begin
    rdData = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (rdMatch[e]) rdData = rdData | dataQ[rdWarp][e];
    end
  end

  // Flag state: a write to a slot takes precedence over invalidation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      liveQ  <= '0;
    end else begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        for (int e = 0; e < ENTRIES; e++) begin
          if ((strobe.allocEn || strobe.updEn) && wrWarp == WARP_W'(w) &&
              strobe.wrSlot == SLOT_IDX_W'(e)) begin
            validQ[w][e] <= 1'b1;
            liveQ[w][e]  <= wrLive;
          end else if (strobe.invEn && rdWarp == WARP_W'(w) &&
                       strobe.invSlot == SLOT_IDX_W'(e)) begin
            validQ[w][e] <= 1'b0;
          end
        end
      end
    end
  end

  // Payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.allocEn || strobe.updEn) begin
      dataQ[wrWarp][wrSlotIdx] <= wrData;
    end
    if (strobe.allocEn) begin
      regQ[wrWarp][wrSlotIdx] <= wrReg;
    end
  end

  // Writeback register: captures the victim before it is overwritten
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0;
    end else begin
      wbValid <= strobe.evictEn;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.evictEn) begin
      wbWarp <= wrWarp;
      wbReg  <= regQ[wrWarp][wrSlotIdx];
      wbData <= dataQ[wrWarp][wrSlotIdx];
    end
  end
endmodule

// File: rtl/rfcCtrl.sv
module rfcCtrl
  import rfcPkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned ENTRIES   = 6,
  localparam int unsigned WARP_W   = $clog2(NUM_WARPS),
  localparam int unsigned SLOT_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [WARP_W-1:0]  wrWarp,
  input  logic [WARP_W-1:0]  rdWarp,
  input  logic               rdLast,
  input  logic [ENTRIES-1:0] wrMatch,
  input  logic [ENTRIES-1:0] wrSlotValid,
  input  logic [ENTRIES-1:0] wrSlotLive,
  input  logic [ENTRIES-1:0] rdMatch,
  output rfcStrobeT          strobe,
  output logic               rdHit
);
  logic [NUM_WARPS-1:0][SLOT_W-1:0] headQ;
  logic [SLOT_W-1:0] victim;
  logic [SLOT_W-1:0] hitSlot;
  logic [SLOT_W-1:0] rdSlot;
  logic              wrHit;
  logic              readKillsVictim;

  function automatic logic [SLOT_W-1:0] encodeSlot(input logic [ENTRIES-1:0] vec);
    logic [SLOT_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vec[i]) idx = SLOT_W'(i);
    end
    return idx;
  endfunction

  assign victim  = headQ[wrWarp];
  assign wrHit   = |wrMatch;
  assign hitSlot = encodeSlot(wrMatch);
  assign rdSlot  = encodeSlot(rdMatch);
  assign rdHit   = |rdMatch;

  // A last-read retiring the victim slot this cycle makes it dead
  assign readKillsVictim = rdHit && rdLast && (rdWarp == wrWarp) && (rdSlot == victim);

  always_comb begin
    strobe         = '0;
    strobe.allocEn = wrValid && !wrHit;
    strobe.updEn   = wrValid && wrHit;
    strobe.wrSlot  = SLOT_IDX_W'(wrHit ? hitSlot : victim);
    strobe.invEn   = rdHit && rdLast;
    strobe.invSlot = SLOT_IDX_W'(rdSlot);
    strobe.evictEn = wrValid && !wrHit && wrSlotValid[victim] &&
                     wrSlotLive[victim] && !readKillsVictim;
  end

  // Allocation ring head per warp
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
    end else if (wrValid && !wrHit) begin
      headQ[wrWarp] <= (victim == SLOT_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
    end
  end
endmodule

// File: rtl/liveRegCache.sv
module liveRegCache
  import rfcPkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned ENTRIES   = 6,
  parameter int unsigned REG_W     = 6,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned WARP_W   = $clog2(NUM_WARPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [WARP_W-1:0] wrWarp,
  input  logic [REG_W-1:0]  wrReg,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLive,
  input  logic              rdValid,
  input  logic [WARP_W-1:0] rdWarp,
  input  logic [REG_W-1:0]  rdReg,
  input  logic              rdLast,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData,
  output logic              wbValid,
  output logic [WARP_W-1:0] wbWarp,
  output logic [REG_W-1:0]  wbReg,
  output logic [DATA_W-1:0] wbData
);
  rfcStrobeT          strobe;
  logic [ENTRIES-1:0] wrMatch;
  logic [ENTRIES-1:0] wrSlotValid;
  logic [ENTRIES-1:0] wrSlotLive;
  logic [ENTRIES-1:0] rdMatch;

  rfcCtrl #(.NUM_WARPS(NUM_WARPS), .ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrWarp(wrWarp), .rdWarp(rdWarp),
    .rdLast(rdLast), .wrMatch(wrMatch), .wrSlotValid(wrSlotValid),
    .wrSlotLive(wrSlotLive), .rdMatch(rdMatch), .strobe(strobe), .rdHit(rdHit)
  );

  rfcData #(.NUM_WARPS(NUM_WARPS), .ENTRIES(ENTRIES), .REG_W(REG_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .wrWarp(wrWarp), .wrReg(wrReg), .wrData(wrData),
    .wrLive(wrLive), .rdValid(rdValid), .rdWarp(rdWarp), .rdReg(rdReg),
    .strobe(strobe), .wrMatch(wrMatch), .wrSlotValid(wrSlotValid),
    .wrSlotLive(wrSlotLive), .rdMatch(rdMatch), .rdData(rdData),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg), .wbData(wbData)
  );
endmodule

// File: rtl/liveRegCacheChk.sv
module liveRegCacheChk #(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned ENTRIES   = 6,
  parameter int unsigned REG_W     = 6,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned WARP_W   = $clog2(NUM_WARPS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [WARP_W-1:0] wrWarp,
  input logic [REG_W-1:0]  wrReg,
  input logic [DATA_W-1:0] wrData,
  input logic              rdValid,
  input logic [WARP_W-1:0] rdWarp,
  input logic [REG_W-1:0]  rdReg,
  input logic              rdLast,
  input logic              rdHit,
  input logic [DATA_W-1:0] rdData,
  input logic              wbValid,
  input logic [WARP_W-1:0] wbWarp
);
  initial begin
    p_slot_index_fits: assert (ENTRIES <= (1 << rfcPkg::SLOT_IDX_W) && ENTRIES > 1);
  end

  // R1: reset leaves no writeback pending
  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !wbValid);

  // R2: no lookup, no hit
  p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> !rdHit);

  // R2: a freshly written register hits with its data on the next cycle
  p_write_then_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid ##1 (rdValid && rdWarp == $past(wrWarp) && rdReg == $past(wrReg))
    |-> (rdHit && rdData == $past(wrData)));

  // R3: misses return zero data
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdHit) |-> rdData == '0);

  // R5: writeback is only ever the consequence of a write in the prior cycle
  p_wb_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> ($past(wrValid) && wbWarp == $past(wrWarp)));

  // R7: a consumed entry is gone next cycle unless rewritten in that cycle
  p_last_read_gone_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdLast && rdHit && !(wrValid && wrWarp == rdWarp && wrReg == rdReg))
    |=> !(rdValid && rdWarp == $past(rdWarp) && rdReg == $past(rdReg) && rdHit));
endmodule

bind liveRegCache liveRegCacheChk #(
  .NUM_WARPS(NUM_WARPS), .ENTRIES(ENTRIES), .REG_W(REG_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrWarp(wrWarp), .wrReg(wrReg),
  .wrData(wrData), .rdValid(rdValid), .rdWarp(rdWarp), .rdReg(rdReg),
  .rdLast(rdLast), .rdHit(rdHit), .rdData(rdData), .wbValid(wbValid),
  .wbWarp(wbWarp)
);

// File: tb/tb_liveRegCache.sv
`timescale 1ns/1ps
module tb_liveRegCache;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrValid, wrLive, rdValid, rdLast;
  logic [2:0]  wrWarp, rdWarp;
  logic [5:0]  wrReg, rdReg;
  logic [31:0] wrData;
  logic        rdHit, wbValid;
  logic [31:0] rdData, wbData;
  logic [2:0]  wbWarp;
  logic [5:0]  wbReg;

  int checks = 0;
  int fails  = 0;
  logic [40:0] expWb[$];
  string       expTag[$];

  always #2 clk = ~clk;

  liveRegCache dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrWarp(wrWarp), .wrReg(wrReg),
    .wrData(wrData), .wrLive(wrLive), .rdValid(rdValid), .rdWarp(rdWarp),
    .rdReg(rdReg), .rdLast(rdLast), .rdHit(rdHit), .rdData(rdData),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg), .wbData(wbData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: every writeback strobe must match the oldest expected item
  always @(negedge clk) begin
    if (rstN && wbValid) begin
      if (expWb.size() == 0) begin
        check(1'b0, "R5", "unexpected writeback", {23'd0, wbWarp, wbReg, wbData}, 64'd0);
      end else begin
        logic [40:0] e;
        string t;
        e = expWb.pop_front();
        t = expTag.pop_front();
        check({wbWarp, wbReg, wbData} == e, t, "writeback",
              {23'd0, wbWarp, wbReg, wbData}, {23'd0, e});
      end
    end
  end

  // Driver: one cycle of stimulus; lookup results checked combinationally
  task automatic step(input bit wv, input int ww, input int wr, input int wd, input bit wl,
                      input bit rv, input int rw, input int rr, input bit rl,
                      input bit eh, input int ed,
                      input bit ew, input int er, input int edw, input string tag);
    @(negedge clk);
    wrValid = wv; wrWarp = 3'(ww); wrReg = 6'(wr); wrData = 32'(wd); wrLive = wl;
    rdValid = rv; rdWarp = 3'(rw); rdReg = 6'(rr); rdLast = rl;
    if (ew) begin
      expWb.push_back({3'(ww), 6'(er), 32'(edw)});
      expTag.push_back(tag);
    end
    #1;
    if (rv) begin
      check(rdHit == eh, tag, "rdHit", 64'(rdHit), 64'(eh));
      check(rdData == 32'(eh ? ed : 0), tag, "rdData", 64'(rdData), 64'(eh ? ed : 0));
    end
  endtask

  task automatic wrOp(input int w, input int r, input int d, input bit l,
                      input bit ew, input int er, input int ed, input string tag);
    step(1, w, r, d, l, 0, 0, 0, 0, 0, 0, ew, er, ed, tag);
  endtask

  task automatic rdOp(input int w, input int r, input bit last,
                      input bit eh, input int ed, input string tag);
    step(0, 0, 0, 0, 0, 1, w, r, last, eh, ed, 0, 0, 0, tag);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", "timeout", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    wrValid = 0; wrWarp = 0; wrReg = 0; wrData = 0; wrLive = 0;
    rdValid = 0; rdWarp = 0; rdReg = 0; rdLast = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: empty after reset
    rdOp(0, 0, 0, 0, 0, "R1");
    check(wbValid == 1'b0, "R1", "wbValid after reset", 64'(wbValid), 64'd0);

    // R2: fill warp 0 with registers 1..6
    for (int i = 1; i <= 6; i++) wrOp(0, i, 100 + i, 1, 0, 0, 0, "R2");
    rdOp(0, 3, 0, 1, 103, "R2");
    rdOp(1, 3, 0, 0, 0, "R4");
    rdOp(0, 9, 0, 0, 0, "R3");

    // R5: FIFO replacement with live writeback
    wrOp(0, 7, 107, 1, 1, 1, 101, "R5");
    rdOp(0, 1, 0, 0, 0, "R5");
    wrOp(0, 8, 108, 1, 1, 2, 102, "R5");

    // R7: last read invalidates; the freed slot is reused silently
    rdOp(0, 3, 1, 1, 103, "R7");
    rdOp(0, 3, 0, 0, 0, "R7");
    wrOp(0, 10, 110, 1, 0, 0, 0, "R7");

    // R8: in-place update does not advance the ring
    wrOp(0, 4, 555, 1, 0, 0, 0, "R8");
    rdOp(0, 4, 0, 1, 555, "R8");
    wrOp(0, 11, 111, 1, 1, 4, 555, "R8");

    // R6: a value made dead is dropped on replacement
    wrOp(0, 5, 77, 0, 0, 0, 0, "R6");
    wrOp(0, 12, 112, 1, 0, 0, 0, "R6");

    // R10: allocation replaces the entry a last-read consumes in the same cycle
    step(1, 0, 13, 113, 1, 1, 0, 6, 1, 1, 106, 0, 0, 0, "R10");

    // R9: write and last-read of the same register in the same cycle
    step(1, 0, 7, 999, 1, 1, 0, 7, 1, 1, 107, 0, 0, 0, "R9");
    rdOp(0, 7, 0, 1, 999, "R9");

    // R11: plain reads keep the entry
    rdOp(0, 8, 0, 1, 108, "R11");
    rdOp(0, 8, 0, 1, 108, "R11");

    // R4: warp 7 is independent of warp 0
    wrOp(7, 1, 7001, 1, 0, 0, 0, "R4");
    rdOp(7, 1, 0, 1, 7001, "R4");
    rdOp(1, 1, 0, 0, 0, "R4");
    rdOp(0, 8, 0, 1, 108, "R4");
    for (int i = 2; i <= 6; i++) wrOp(7, i, 7000 + i, 1, 0, 0, 0, "R4");
    wrOp(7, 40, 7040, 1, 1, 1, 7001, "R4");

    // R3: misses allocate nothing and leave the ring alone
    rdOp(3, 20, 0, 0, 0, "R3");
    for (int i = 30; i <= 35; i++) wrOp(3, i, 3000 + i, 1, 0, 0, 0, "R3");
    rdOp(3, 20, 0, 0, 0, "R3");
    wrOp(3, 36, 3036, 1, 1, 30, 3030, "R3");

    idle();
    idle();
    check(expWb.size() == 0, "R5", "writebacks outstanding", 64'(expWb.size()), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule